// File: doc/BRIEF.md
# Periodic Comparator Event Timer

A single-channel event timer for software use. A 32-bit main counter steps once per clock while a global run bit is set. A single comparator is checked against the counter. When the counter equals the comparator, the block can latch an interrupt status flag. In periodic mode, every match also advances the comparator by a stored period, so the next match is already scheduled. In one-shot mode the comparator stays where it is.

Software reaches the timer through a small synchronous register bus with four word registers. A comparator write does different things depending on the mode. In periodic mode it normally reprograms only the hidden period. If software first arms the load bit in the timer configuration register, one comparator write loads both the live comparator and the period, and the load bit then drops by itself. This lets the start-up sequence "stop, clear counter, arm load, write comparator once, start" produce correct periodic ticks.

Top module: `evt_timer`

## Requirements
- R1: While the run bit (global register, address 0, bit 0) is clear, the counter holds its value and no interrupt status is latched, even when counter and comparator are equal.
- R2: While the run bit is set, the counter (address 1) increases by one every clock and wraps from FFFFFFFFh to 0.
- R3: A write to address 1 loads the counter with the written value.
- R4: In periodic mode (timer configuration, address 2, bit 1), a write to the comparator (address 3) with the load bit (address 2, bit 2) clear changes only the stored period. The live comparator keeps its value.
- R5: In periodic mode, a comparator write with the load bit set loads both the live comparator and the stored period with the written value.
- R6: The load bit clears itself on the clock edge that performs a comparator write.
- R7: In periodic mode, on each clock where the run bit is set and the counter equals the comparator, the comparator increases by the stored period, modulo 2^32.
- R8: In one-shot mode (address 2, bit 1 clear), a comparator write always loads the live comparator, and a match leaves the comparator unchanged.
- R9: The status flag (address 2, bit 3) is set on a match only when both the run bit and the interrupt enable (address 2, bit 0) are set. The interrupt output equals status AND interrupt enable, so clearing the enable masks the output without clearing status.
- R10: Writing 1 to address 2 bit 3 clears the status flag. Writing 0 there leaves it unchanged.
- R11: A read returns data on the cycle after the read strobe. Address 0 returns the run bit, address 2 returns {status, load, periodic, interrupt enable} in bits 3..0, and address 3 returns the live comparator, not the period. After reset, all registers read 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| irq_o | output | 1 | Level interrupt |

## Verification
The stored period can only be observed through later comparator advances. A wrong period therefore stays hidden until the next periodic match, and then shows up as a comparator readback that is off by the difference. For this reason each period update is followed by a run that crosses a match before the comparator is read back. A load bit that fails to clear, or a write routed to the wrong register, shows up either at the very next comparator read or one match later. A status or gating error reaches irq_o on the clock after the match.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    REG_GLB  = 2'd0,
    REG_CNT  = 2'd1,
    REG_TCFG = 2'd2,
    REG_CMP  = 2'd3
  } reg_sel_e;

  localparam int GL_RUN  = 0;
  localparam int TC_IEN  = 0;
  localparam int TC_PER  = 1;
  localparam int TC_LOAD = 2;
  localparam int TC_STS  = 3;
  localparam int TC_BITS = 4;
endpackage

// File: rtl/evt_timer_counter.sv
module evt_timer_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_ce;

  assign cnt_ce = ld | run_en;

  always_comb begin
    cnt_n = cnt_q;
    if (ld)          cnt_n = ld_val;
    else if (run_en) cnt_n = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_n;
  end

  assign count = cnt_q;
endmodule

// File: rtl/evt_timer_cmp.sv
module evt_timer_cmp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic [W-1:0] count,
  input  logic         periodic,
  input  logic         load_arm,
  input  logic         cmp_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cmp_live,
  output logic [W-1:0] period,
  output logic         match
);
  logic [W-1:0] live_q, live_n, per_q, per_n;
  logic         live_ce, per_ce;

  assign match = run_en && (count == live_q);

  always_comb begin
    live_n  = live_q;
    per_n   = per_q;
    live_ce = 1'b0;
    per_ce  = 1'b0;
    if (cmp_wr) begin
      if (!periodic) begin
        live_n  = wdata;
        live_ce = 1'b1;
      end else begin
        per_n  = wdata;
        per_ce = 1'b1;
        if (load_arm) begin
          live_n  = wdata;
          live_ce = 1'b1;
        end
      end
    end else if (match && periodic) begin
      live_n  = live_q + per_q;
      live_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live_q <= '0;
    else if (live_ce) live_q <= live_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      per_q <= '0;
    else if (per_ce) per_q <= per_n;
  end

  assign cmp_live = live_q;
  assign period   = per_q;
endmodule

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic [TC_BITS-1:0] bus_wd,
  input  logic         bus_we,
  input  logic         bus_re,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp_live,
  input  logic         match,
  output logic         run_en,
  output logic         irq_en,
  output logic         periodic,
  output logic         load_arm,
  output logic         status,
  output logic         cnt_wr,
  output logic         cmp_wr,
  output logic         tcfg_wr,
  output logic [W-1:0] rdata,
  output logic         irq_o
);
  reg_sel_e     sel;
  logic         glb_wr;
  logic         run_q, ien_q, per_q, arm_q, sts_q;
  logic         run_n, ien_n, per_n, arm_n, sts_n;
  logic         sts_set, sts_clr;
  logic [W-1:0] rd_q, rd_n;

  assign sel     = reg_sel_e'(bus_addr);
  assign glb_wr  = bus_we && (sel == REG_GLB);
  assign cnt_wr  = bus_we && (sel == REG_CNT);
  assign tcfg_wr = bus_we && (sel == REG_TCFG);
  assign cmp_wr  = bus_we && (sel == REG_CMP);

  assign sts_set = match && ien_q;
  assign sts_clr = tcfg_wr && bus_wd[TC_STS];

  always_comb begin
    run_n = glb_wr  ? bus_wd[GL_RUN] : run_q;
    ien_n = tcfg_wr ? bus_wd[TC_IEN] : ien_q;
    per_n = tcfg_wr ? bus_wd[TC_PER] : per_q;
    if (tcfg_wr)     arm_n = bus_wd[TC_LOAD];
    else if (cmp_wr) arm_n = 1'b0;
    else             arm_n = arm_q;
    sts_n = sts_set | (sts_q & ~sts_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
      per_q <= 1'b0;
      arm_q <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      run_q <= run_n;
      ien_q <= ien_n;
      per_q <= per_n;
      arm_q <= arm_n;
      sts_q <= sts_n;
    end
  end

  always_comb begin
    rd_n = '0;
    case (sel)
      REG_GLB:  rd_n[GL_RUN] = run_q;
      REG_CNT:  rd_n = count;
      REG_TCFG: begin
        rd_n[TC_IEN]  = ien_q;
        rd_n[TC_PER]  = per_q;
        rd_n[TC_LOAD] = arm_q;
        rd_n[TC_STS]  = sts_q;
      end
      default:  rd_n = cmp_live;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (bus_re) rd_q <= rd_n;
  end

  assign run_en   = run_q;
  assign irq_en   = ien_q;
  assign periodic = per_q;
  assign load_arm = arm_q;
  assign status   = sts_q;
  assign rdata    = rd_q;
  assign irq_o    = sts_q & ien_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_sn;
  logic             run_en, irq_en, periodic, load_arm, status_q;
  logic             cnt_wr, cmp_wr, tcfg_wr, match;
  logic [CNT_W-1:0] count_q, cmp_live, period_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  evt_timer_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sn),
    .run_en (run_en),
    .ld     (cnt_wr),
    .ld_val (bus_wdata),
    .count  (count_q)
  );

  evt_timer_cmp #(.W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_sn),
    .run_en   (run_en),
    .count    (count_q),
    .periodic (periodic),
    .load_arm (load_arm),
    .cmp_wr   (cmp_wr),
    .wdata    (bus_wdata),
    .cmp_live (cmp_live),
    .period   (period_q),
    .match    (match)
  );

  evt_timer_ctrl #(.W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sn),
    .bus_addr (bus_addr),
    .bus_wd   (bus_wdata[TC_BITS-1:0]),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .count    (count_q),
    .cmp_live (cmp_live),
    .match    (match),
    .run_en   (run_en),
    .irq_en   (irq_en),
    .periodic (periodic),
    .load_arm (load_arm),
    .status   (status_q),
    .cnt_wr   (cnt_wr),
    .cmp_wr   (cmp_wr),
    .tcfg_wr  (tcfg_wr),
    .rdata    (bus_rdata),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic         irq_en,
  input logic         periodic,
  input logic         load_arm,
  input logic         status,
  input logic         cnt_wr,
  input logic         cmp_wr,
  input logic         tcfg_wr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp,
  input logic [W-1:0] period
);
  logic hit;
  assign hit = run_en && (count == cmp);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr) |=> (count == $past(count)));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cnt_wr) |=> (count == W'($past(count) + W'(1))));

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count == $past(wdata)));

  assert_period_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && periodic && !load_arm) |=>
      (cmp == $past(cmp) && period == $past(wdata)));

  assert_load_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && periodic && load_arm) |=>
      (cmp == $past(wdata) && period == $past(wdata)));

  assert_arm_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && load_arm) |=> !load_arm);

  assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic && hit && !cmp_wr) |=> (cmp == W'($past(cmp) + $past(period))));

  assert_oneshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic && !cmp_wr) |=> $stable(cmp));

  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> ($past(run_en) && $past(irq_en)));

  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tcfg_wr && wdata[3] && !(hit && irq_en)) |=> !status);
endmodule

bind evt_timer evt_timer_chk #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sn),
  .run_en   (run_en),
  .irq_en   (irq_en),
  .periodic (periodic),
  .load_arm (load_arm),
  .status   (status_q),
  .cnt_wr   (cnt_wr),
  .cmp_wr   (cmp_wr),
  .tcfg_wr  (tcfg_wr),
  .wdata    (bus_wdata),
  .count    (count_q),
  .cmp      (cmp_live),
  .period   (period_q)
);

// File: tb/evt_timer_test.sv
module evt_timer_test;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_I = 2'd2, OP_Q = 2'd3;
  localparam logic [1:0] A_GLB = 2'd0, A_CNT = 2'd1, A_TCFG = 2'd2, A_CMP = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 62;
  localparam vec_t VEC [NV] = '{
    '{OP_Q, A_GLB,  32'd0,          32'd0,          4'd11}, // R11 irq low after reset
    '{OP_W, A_CNT,  32'd5,          32'd0,          4'd3},
    '{OP_I, A_GLB,  32'd3,          32'd0,          4'd1},
    '{OP_R, A_CNT,  32'd0,          32'd5,          4'd1},  // R1 R3 held value
    '{OP_W, A_TCFG, 32'h7,          32'd0,          4'd5},
    '{OP_R, A_TCFG, 32'd0,          32'h7,          4'd11}, // R11 field layout
    '{OP_W, A_CNT,  32'd0,          32'd0,          4'd3},
    '{OP_W, A_CMP,  32'd10,         32'd0,          4'd5},
    '{OP_R, A_TCFG, 32'd0,          32'h3,          4'd6},  // R6 load bit dropped
    '{OP_R, A_CMP,  32'd0,          32'd10,         4'd5},  // R5 live loaded
    '{OP_W, A_GLB,  32'd1,          32'd0,          4'd2},
    '{OP_I, A_GLB,  32'd15,         32'd0,          4'd2},
    '{OP_W, A_GLB,  32'd0,          32'd0,          4'd1},
    '{OP_R, A_CNT,  32'd0,          32'd16,         4'd2},  // R2
    '{OP_R, A_CMP,  32'd0,          32'd20,         4'd7},  // R7 R5 period 10
    '{OP_R, A_TCFG, 32'd0,          32'hB,          4'd9},  // R9 status set
    '{OP_Q, A_GLB,  32'd0,          32'd1,          4'd9},  // R9 irq high
    '{OP_W, A_CMP,  32'd5,          32'd0,          4'd4},
    '{OP_R, A_CMP,  32'd0,          32'd20,         4'd4},  // R4 live untouched
    '{OP_W, A_GLB,  32'd1,          32'd0,          4'd2},
    '{OP_I, A_GLB,  32'd6,          32'd0,          4'd2},
    '{OP_W, A_GLB,  32'd0,          32'd0,          4'd1},
    '{OP_R, A_CNT,  32'd0,          32'd23,         4'd2},  // R2
    '{OP_R, A_CMP,  32'd0,          32'd25,         4'd4},  // R4 period now 5
    '{OP_W, A_TCFG, 32'h2,          32'd0,          4'd9},
    '{OP_Q, A_GLB,  32'd0,          32'd0,          4'd9},  // R9 masked
    '{OP_R, A_TCFG, 32'd0,          32'hA,          4'd9},  // R9 status kept
    '{OP_W, A_TCFG, 32'hB,          32'd0,          4'd10},
    '{OP_R, A_TCFG, 32'd0,          32'h3,          4'd10}, // R10 cleared
    '{OP_Q, A_GLB,  32'd0,          32'd0,          4'd10}, // R10
    '{OP_W, A_TCFG, 32'h2,          32'd0,          4'd9},
    '{OP_W, A_GLB,  32'd1,          32'd0,          4'd2},
    '{OP_I, A_GLB,  32'd4,          32'd0,          4'd2},
    '{OP_W, A_GLB,  32'd0,          32'd0,          4'd1},
    '{OP_R, A_CMP,  32'd0,          32'd30,         4'd7},  // R7
    '{OP_R, A_TCFG, 32'd0,          32'h2,          4'd9},  // R9 no status w/o enable
    '{OP_W, A_TCFG, 32'h1,          32'd0,          4'd8},
    '{OP_W, A_CMP,  32'd31,         32'd0,          4'd8},
    '{OP_R, A_CMP,  32'd0,          32'd31,         4'd8},  // R8 live load
    '{OP_W, A_GLB,  32'd1,          32'd0,          4'd2},
    '{OP_I, A_GLB,  32'd5,          32'd0,          4'd2},
    '{OP_W, A_GLB,  32'd0,          32'd0,          4'd1},
    '{OP_R, A_CNT,  32'd0,          32'd34,         4'd2},  // R2
    '{OP_R, A_CMP,  32'd0,          32'd31,         4'd8},  // R8 no advance
    '{OP_R, A_TCFG, 32'd0,          32'h9,          4'd9},  // R9
    '{OP_Q, A_GLB,  32'd0,          32'd1,          4'd9},  // R9
    '{OP_W, A_TCFG, 32'h9,          32'd0,          4'd10},
    '{OP_W, A_CNT,  32'd40,         32'd0,          4'd3},
    '{OP_W, A_CMP,  32'd40,         32'd0,          4'd8},
    '{OP_I, A_GLB,  32'd3,          32'd0,          4'd1},
    '{OP_R, A_TCFG, 32'd0,          32'h1,          4'd1},  // R1 no status while stopped
    '{OP_W, A_CNT,  32'hFFFF_FFFE,  32'd0,          4'd3},
    '{OP_W, A_GLB,  32'd1,          32'd0,          4'd2},
    '{OP_I, A_GLB,  32'd2,          32'd0,          4'd2},
    '{OP_W, A_GLB,  32'd0,          32'd0,          4'd2},
    '{OP_R, A_CNT,  32'd0,          32'd1,          4'd2},  // R2 wrap
    '{OP_W, A_TCFG, 32'h6,          32'd0,          4'd5},
    '{OP_W, A_CMP,  32'hFFFF_FFF0,  32'd0,          4'd5},
    '{OP_W, A_CMP,  32'h20,         32'd0,          4'd4},
    '{OP_W, A_CNT,  32'hFFFF_FFEE,  32'd0,          4'd3},
    '{OP_W, A_GLB,  32'd1,          32'd0,          4'd7},
    '{OP_I, A_GLB,  32'd3,          32'd0,          4'd7}
  };

  logic        clk, rst_n, bus_we, bus_re, irq_o;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int          n_checks, n_errors;
  logic        done;

  evt_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    n_checks = 0; n_errors = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_W: bus_wr(VEC[i].addr, VEC[i].data);
        OP_R: begin
          bus_rd(VEC[i].addr, rd);
          check(int'(VEC[i].req), rd, VEC[i].exp);
        end
        OP_I: idle(int'(VEC[i].data));
        default: check(int'(VEC[i].req), {31'd0, irq_o}, VEC[i].exp);
      endcase
    end

    // R7: table ended running; periodic advance across 2^32 wrap
    bus_wr(A_GLB, 32'd0);
    bus_rd(A_CNT, rd);  check(7, rd, 32'hFFFF_FFF2);
    bus_rd(A_CMP, rd);  check(7, rd, 32'h10);
    bus_rd(A_TCFG, rd); check(6, rd, 32'h2); // R6 still clear

    // R11: reset while running returns every register to 0
    bus_wr(A_TCFG, 32'h3);
    bus_wr(A_GLB, 32'd1);
    idle(5);
    rst_n = 1'b0;
    #1;
    check(11, {31'd0, irq_o}, 32'd0);
    idle(2);
    rst_n = 1'b1;
    idle(4);
    bus_rd(A_GLB, rd);  check(11, rd, 32'd0);
    bus_rd(A_CNT, rd);  check(11, rd, 32'd0);
    bus_rd(A_TCFG, rd); check(11, rd, 32'd0);
    bus_rd(A_CMP, rd);  check(11, rd, 32'd0);
    idle(3);
    bus_rd(A_CNT, rd);  check(1, rd, 32'd0); // R1 stays stopped after reset

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule